// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the serial control front end of an eight-line general purpose I/O expander. A host on a two-wire bus (open-drain SCL and SDA) uses it to write and read a small bank of control registers. The block oversamples both bus lines with a fast system clock. It recognises the bus framing events itself and answers one of two fixed 7-bit device addresses. A strap input picks which of the two addresses applies.

A write transfer works as follows. The first byte after the address loads an internal register pointer. Each later byte goes out on the register port as a one-cycle write strobe, and the pointer then advances. A read transfer shifts out the register at the current pointer, MSB first, and the pointer advances after each byte. The slave never drives SDA high. It only asserts a pull-low enable, which the pad ring turns into an open-drain driver. An active-low reset input holds the whole interface in its initial state and makes it deaf to the bus.

Top module: `gpx_i2c_slave`

## Requirements
- R1: With `addr_sel_i` = 0 the slave answers device address 7'b0001001: after the address byte it holds SDA low during the ninth SCL high phase (ACK).
- R2: With `addr_sel_i` = 1 the slave answers 7'b0001110 and ignores 7'b0001001; with the strap at 0 it ignores 7'b0001110.
- R3: After a non-matching address, the slave acknowledges nothing, issues no register write and keeps SDA released until the next START.
- R4: In a write transfer the first data byte loads the register pointer without a write. Each later byte is acknowledged and produces a one-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R5: The register pointer advances by one after each written data byte and after each byte loaded for reading.
- R6: A read transfer (R/W bit = 1) shifts out `reg_rdata_i` for the current pointer, MSB first. The slave pulls SDA low only for 0 bits.
- R7: When the master answers a read byte with NACK (SDA high), the slave releases SDA and drives nothing more until the next START.
- R8: A START that arrives before any STOP restarts address reception. This lets a pointer write be followed directly by a read.
- R9: After a STOP (SDA rising while SCL is high) the slave releases SDA. It then ignores bus clocks until a START.
- R10: While `rst_n` is low, `sda_pull_o` and `reg_we_o` stay low and bus traffic gets no response.
- R11: `sda_pull_o` changes only while SCL is low, so SDA is stable for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low reset / power-down |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_sel_i | input | 1 | Address strap, selects one of two device addresses |
| reg_addr_o | output | 8 | Register pointer; the address for writes and reads |
| reg_wdata_o | output | 8 | Write data, valid while `reg_we_o` is high |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data of the register at `reg_addr_o` |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except for START and STOP. A STOP or repeated START is never issued while the slave is pulling SDA low. Each SCL phase lasts many system clocks, so the synchroniser latency settles before the next edge. The bench master holds every quarter bit for ten system clocks and only moves its own SDA with SCL low or at deliberate framing events. It issues STOP and repeated START only after the slave has released the line.

// File: rtl/gpx_i2c_pkg.sv
package gpx_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_SKIP
    } gpx_state_e;

    // bus events produced by the synchroniser, one cycle wide each
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } gpx_evt_t;

endpackage

// File: rtl/gpx_i2c_sync.sv
module gpx_i2c_sync
    import gpx_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output gpx_evt_t evt_o,
    output logic     scl_lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t d, q;
    logic  scl_now, sda_now;

    assign scl_now = q.scl_sh[STAGES-1];
    assign sda_now = q.sda_sh[STAGES-1];

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                d.scl_sh = scl_i;
                d.sda_sh = sda_i;
                d.scl_p  = scl_now;
                d.sda_p  = sda_now;
            end
        end else begin : g_many
            always_comb begin
                d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
                d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
                d.scl_p  = scl_now;
                d.sda_p  = sda_now;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    always_comb begin
        evt_o.scl_rise = scl_now & ~q.scl_p;
        evt_o.scl_fall = ~scl_now & q.scl_p;
        evt_o.start    = scl_now & q.scl_p & q.sda_p & ~sda_now;
        evt_o.stop     = scl_now & q.scl_p & ~q.sda_p & sda_now;
        evt_o.sda      = sda_now;
    end

    assign scl_lvl_o = scl_now;

endmodule

// File: rtl/gpx_i2c_ctrl.sv
module gpx_i2c_ctrl
    import gpx_i2c_pkg::*;
#(
    parameter int         DW      = 8,
    parameter int         PW      = 8,
    parameter logic [6:0] ADDR_LO = 7'b0001001,
    parameter logic [6:0] ADDR_HI = 7'b0001110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gpx_evt_t      evt_i,
    input  logic          addr_sel_i,
    input  logic [DW-1:0] rdata_i,
    output logic          sda_pull_o,
    output logic [PW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    typedef struct packed {
        gpx_state_e    st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          rw;
        logic          first;
        logic [PW-1:0] ptr;
        logic          pull;
        logic          we;
        logic [DW-1:0] wdata;
    } ctrl_t;

    ctrl_t      d, q;
    logic [6:0] my_addr;

    assign my_addr = addr_sel_i ? ADDR_HI : ADDR_LO;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (q.we) d.ptr = q.ptr + PW'(1);

        if (evt_i.stop) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else if (evt_i.start) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (evt_i.scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], evt_i.sda};
                        d.cnt = q.cnt + CW'(1);
                    end else if (evt_i.scl_fall && q.cnt == LAST) begin
                        if (q.sh[DW-1:1] == my_addr) begin
                            d.pull = 1'b1;
                            d.rw   = q.sh[0];
                            d.st   = ST_AACK;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_AACK, ST_RACK: begin
                    if (q.st == ST_RACK && evt_i.scl_rise && evt_i.sda) begin
                        d.st = ST_SKIP;
                    end else if (evt_i.scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh   = rdata_i;
                            d.pull = ~rdata_i[DW-1];
                            d.ptr  = q.ptr + PW'(1);
                            d.st   = ST_RBYTE;
                        end else begin
                            d.pull  = 1'b0;
                            d.first = 1'b1;
                            d.st    = ST_WBYTE;
                        end
                    end
                end
                ST_WBYTE: begin
                    if (evt_i.scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], evt_i.sda};
                        d.cnt = q.cnt + CW'(1);
                    end else if (evt_i.scl_fall && q.cnt == LAST) begin
                        d.pull = 1'b1;
                        d.st   = ST_WACK;
                        if (q.first) begin
                            d.ptr   = PW'(q.sh);
                            d.first = 1'b0;
                        end else begin
                            d.we    = 1'b1;
                            d.wdata = q.sh;
                        end
                    end
                end
                ST_WACK: begin
                    if (evt_i.scl_fall) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_WBYTE;
                    end
                end
                ST_RBYTE: begin
                    if (evt_i.scl_rise) begin
                        d.cnt = q.cnt + CW'(1);
                    end else if (evt_i.scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.pull = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.sh   = q.sh << 1;
                            d.pull = ~q.sh[DW-2];
                        end
                    end
                end
                default: d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign addr_o     = q.ptr;
    assign wdata_o    = q.wdata;
    assign we_o       = q.we;

endmodule

// File: rtl/gpx_i2c_slave.sv
module gpx_i2c_slave
    import gpx_i2c_pkg::*;
#(
    parameter int         DW          = 8,
    parameter int         PW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LO     = 7'b0001001,
    parameter logic [6:0] ADDR_HI     = 7'b0001110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull_o,
    input  logic          addr_sel_i,
    output logic [PW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_we_o,
    input  logic [DW-1:0] reg_rdata_i
);

    gpx_evt_t evt;
    logic     scl_lvl;

    gpx_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .evt_o     (evt),
        .scl_lvl_o (scl_lvl)
    );

    gpx_i2c_ctrl #(
        .DW      (DW),
        .PW      (PW),
        .ADDR_LO (ADDR_LO),
        .ADDR_HI (ADDR_HI)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .addr_sel_i (addr_sel_i),
        .rdata_i    (reg_rdata_i),
        .sda_pull_o (sda_pull_o),
        .addr_o     (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .we_o       (reg_we_o)
    );

endmodule

// File: rtl/gpx_i2c_slave_chk.sv
module gpx_i2c_slave_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          stop_evt,
    input logic          sda_pull_o,
    input logic          reg_we_o,
    input logic [PW-1:0] reg_addr_o
);

    // R11: the pull enable only moves one cycle after SCL was seen low
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_lvl));

    // R4: a write strobe lasts exactly one cycle
    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R5: the pointer advances right after each write
    p_ptr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + PW'(1)));

    // R9: a STOP leaves SDA released
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

    // R10: nothing is driven while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (!sda_pull_o && !reg_we_o);
        end
    end

endmodule

bind gpx_i2c_slave gpx_i2c_slave_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .stop_evt   (evt.stop),
    .sda_pull_o (sda_pull_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/gpx_i2c_slave_bench.sv
module gpx_i2c_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_pull;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic       sda_bus;
    logic [7:0] mem [16];
    int         total = 0, bad = 0, we_cnt = 0, r11_viol = 0;
    logic       pull_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign reg_rdata = mem[reg_addr[3:0]];

    gpx_i2c_slave u_gpx_i2c_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .addr_sel_i  (addr_sel),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata)
    );

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[3:0]] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    // R11 monitor: pull enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_pull != pull_prev) r11_viol++;
        pull_prev <= sda_pull;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_bus;  qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic raw;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(raw);
        ack = ~raw;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(nack);
    endtask

    task automatic t_reset();
        logic ack;
        int   w0;
        chk("R10 pull in reset", int'(sda_pull), 0);
        chk("R10 we in reset", int'(reg_we), 0);
        w0 = we_cnt;
        bus_start();
        send_byte(8'h12, ack);
        chk("R10 no ack in reset", int'(ack), 0);
        send_byte(8'h00, ack);
        send_byte(8'h55, ack);
        bus_stop();
        chk("R10 no write in reset", we_cnt - w0, 0);
        rst_n = 1'b1;
        qw();
    endtask

    task automatic t_write_lo();
        logic ack;
        int   w0;
        addr_sel = 1'b0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h12, ack);
        chk("R1 address ack strap0", int'(ack), 1);
        send_byte(8'h03, ack);
        chk("R4 pointer byte ack", int'(ack), 1);
        chk("R4 pointer byte no write", we_cnt - w0, 0);
        send_byte(8'hA5, ack);
        chk("R4 data ack", int'(ack), 1);
        send_byte(8'h3C, ack);
        bus_stop();
        chk("R4 write count", we_cnt - w0, 2);
        chk("R4 mem[3]", int'(mem[3]), 'hA5);
        chk("R5 mem[4]", int'(mem[4]), 'h3C);
        chk("R9 released after stop", int'(sda_pull), 0);
    endtask

    task automatic t_read_rs(input logic [7:0] ptr, input logic [7:0] e0,
                             input logic [7:0] e1);
        logic       ack;
        logic [7:0] v;
        logic       b;
        int         ones = 0;
        bus_start();
        send_byte(8'h12, ack);
        send_byte(ptr, ack);
        bus_start();
        send_byte(8'h13, ack);
        chk("R8 read address after repeated start", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R6 first read byte", int'(v), int'(e0));
        recv_byte(1'b1, v);
        chk("R5 second read byte", int'(v), int'(e1));
        qw();
        chk("R7 released after nack", int'(sda_pull), 0);
        for (int i = 0; i < 9; i++) begin
            rbit(b);
            ones += int'(b);
        end
        chk("R7 silent after nack", ones, 9);
        bus_stop();
    endtask

    task automatic t_pattern();
        logic ack;
        bus_start();
        send_byte(8'h12, ack);
        send_byte(8'h07, ack);
        send_byte(8'h81, ack);
        send_byte(8'h6E, ack);
        bus_stop();
        t_read_rs(8'h07, 8'h81, 8'h6E);
    endtask

    task automatic t_wrong_addr();
        logic ack;
        int   w0;
        addr_sel = 1'b0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h1C, ack);
        chk("R2 other address ignored strap0", int'(ack), 0);
        send_byte(8'h05, ack);
        chk("R3 no ack after mismatch", int'(ack), 0);
        send_byte(8'h99, ack);
        chk("R3 no ack on data", int'(ack), 0);
        chk("R3 no write after mismatch", we_cnt - w0, 0);
        bus_start();
        send_byte(8'h12, ack);
        chk("R8 repeated start after mismatch", int'(ack), 1);
        bus_stop();
    endtask

    task automatic t_strap_hi();
        logic ack;
        addr_sel = 1'b1;
        qw();
        bus_start();
        send_byte(8'h12, ack);
        chk("R2 low address ignored strap1", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'h1C, ack);
        chk("R2 address ack strap1", int'(ack), 1);
        send_byte(8'h0A, ack);
        send_byte(8'h77, ack);
        bus_stop();
        chk("R2 mem[10]", int'(mem[10]), 'h77);
        addr_sel = 1'b0;
    endtask

    task automatic t_no_start_after_stop();
        logic ack;
        scl_m = 1'b0; qw();
        send_byte(8'h12, ack);
        chk("R9 ignored without start", int'(ack), 0);
        bus_stop();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_write_lo();
        t_read_rs(8'h03, 8'hA5, 8'h3C);
        t_pattern();
        t_wrong_addr();
        t_strap_hi();
        t_no_start_after_stop();
        chk("R11 pull stable while SCL high", r11_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule